// File: doc/BRIEF.md
# Projection Peak Centroid Locator

This block takes a binary foreground image one kernel at a time and reports where the centre of a single round bright spot lies. Each kernel carries eight adjacent pixels of one line, and the kernels of a line arrive from left to right. The block builds the column projection of the frame by keeping one counter per column. It also keeps a running foreground count for the current line. When a line ends, the block compares that line's count with the best line seen so far in the frame. For a disc, the longest line and the tallest column both pass through its centre, so their indices give Y and X.

Lines arrive from the bottom of the image upward. The first line of a frame is therefore the bottom row, Y = ROWS-1, and the last line is row 0. After the last kernel of the frame, a search engine reads KW column counters per cycle and keeps the peak. When the search finishes, the coordinates and a no-target flag are registered and a one-cycle done strobe is raised. Kernels that arrive while the search is running are dropped, so the next frame must start after the strobe.

Top module: `peak_centroid_locator`

## Requirements
- R1: While reset is applied, `fix_done`, `cx`, `cy` and `no_target` are all zero.
- R2: A kernel accepted as the k-th kernel of its line places bit i of `kin_bits` in column KW*k+i.
- R3: `cx` is the column holding the most foreground pixels of the frame. When several columns tie, the lowest column index is reported.
- R4: A line replaces the best line only if its foreground count is strictly greater. When lines tie, the line that arrived first is kept.
- R5: `cy` equals ROWS-1 minus the arrival index of the best line, where the first line of a frame has arrival index 0.
- R6: Let E be the clock edge that accepts the kernel with `kin_eol` high on the last line of the frame. `fix_done` is high for exactly the one cycle that follows edge E+COLS/KW.
- R7: `cx`, `cy` and `no_target` change only together with a `fix_done` pulse and hold their values between pulses.
- R8: A frame with no foreground pixel reports `no_target` = 1, `cx` = 0 and `cy` = 0. Any other frame reports `no_target` = 0.
- R9: Kernels presented during the column search are ignored, including those with `kin_sof` or `kin_eol` set. The search result is unaffected.
- R10: A kernel with `kin_sof` high starts a new frame. Column counters, the line count and the best line all restart, so earlier frames have no effect on the result.
- R11: Clock cycles with `kin_valid` low have no effect, whatever the values on `kin_bits`, `kin_sof` and `kin_eol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kin_valid | input | 1 | A kernel is present this cycle |
| kin_bits | input | KW | Binary pixels; bit i is the i-th pixel from the left |
| kin_sof | input | 1 | Marks the first kernel of a frame (qualified by kin_valid) |
| kin_eol | input | 1 | Marks the last kernel of a line (qualified by kin_valid) |
| cx | output | idx_w(COLS) | Column of the peak column count |
| cy | output | idx_w(ROWS) | Row of the peak line count, with row 0 at the top |
| fix_done | output | 1 | One-cycle strobe when new coordinates are valid |
| no_target | output | 1 | The last frame held no foreground |

## Verification
The bench builds the block with COLS=32, ROWS=10 and KW=8. This gives a four-cycle search and 40 kernels per frame, so dozens of complete frames fit in a short run. It also puts the corners within easy reach: the last column, the top and bottom rows, a full line and a full column. With these sizes the tie cases and the exact strobe cycle can be built directly into the test images. Random frames add idle gaps with junk on the inputs, and every frame is followed by stray kernels injected during the search.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACCUM  = 2'd1,
    PH_SEARCH = 2'd2
  } phase_t;

  // index width with a floor of one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pcl_frame_seq.sv
module pcl_frame_seq
  import pcl_pkg::*;
#(
  parameter int COLS = 560,
  parameter int ROWS = 480,
  parameter int KW   = 8,
  parameter int GW   = idx_w(COLS / KW),
  parameter int LW   = idx_w(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic          sof_i,
  input  logic          eol_i,
  output logic          take_o,
  output logic          start_o,
  output logic [GW-1:0] grp_o,
  output logic [LW-1:0] line_o,
  output logic          in_search_o,
  output logic          search_first_o,
  output logic          search_last_o,
  output logic [GW-1:0] sgrp_o
);

  localparam int NG = COLS / KW;

  phase_t          phase_q, phase_d;
  logic [GW-1:0]   kptr_q, kptr_d;
  logic [LW-1:0]   line_q, line_d;
  logic [GW-1:0]   sgrp_q, sgrp_d;
  logic            start, take, frame_last, search_last;
  logic [GW-1:0]   cur_grp;
  logic [LW-1:0]   cur_line;

  always_comb begin
    start       = valid_i && sof_i && (phase_q != PH_SEARCH);
    take        = start || (valid_i && (phase_q == PH_ACCUM));
    cur_grp     = start ? '0 : kptr_q;
    cur_line    = start ? '0 : line_q;
    frame_last  = take && eol_i && (cur_line == LW'(ROWS - 1));
    search_last = (phase_q == PH_SEARCH) && (sgrp_q == GW'(NG - 1));

    kptr_d  = kptr_q;
    line_d  = line_q;
    phase_d = phase_q;
    sgrp_d  = sgrp_q;

    if (take) begin
      kptr_d = eol_i ? '0 : cur_grp + GW'(1);
      line_d = eol_i ? cur_line + LW'(1) : cur_line;
    end

    if (phase_q == PH_SEARCH) begin
      sgrp_d = sgrp_q + GW'(1);
      if (search_last) phase_d = PH_IDLE;
    end

    if (frame_last) begin
      phase_d = PH_SEARCH;
      sgrp_d  = '0;
    end else if (start) begin
      phase_d = PH_ACCUM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      kptr_q  <= '0;
      line_q  <= '0;
      sgrp_q  <= '0;
    end else begin
      phase_q <= phase_d;
      kptr_q  <= kptr_d;
      line_q  <= line_d;
      sgrp_q  <= sgrp_d;
    end
  end

  assign take_o         = take;
  assign start_o        = start;
  assign grp_o          = cur_grp;
  assign line_o         = cur_line;
  assign in_search_o    = (phase_q == PH_SEARCH);
  assign search_first_o = (phase_q == PH_SEARCH) && (sgrp_q == '0);
  assign search_last_o  = search_last;
  assign sgrp_o         = sgrp_q;

  // R6
  search_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    search_last |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/pcl_col_bank.sv
module pcl_col_bank #(
  parameter int COLS = 560,
  parameter int ROWS = 480,
  parameter int KW   = 8,
  parameter int GW   = pcl_pkg::idx_w(COLS / KW),
  parameter int CW   = $clog2(ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             start_i,
  input  logic [GW-1:0]    grp_i,
  input  logic [KW-1:0]    bits_i,
  input  logic [GW-1:0]    rd_grp_i,
  output logic [KW*CW-1:0] rd_vals_o
);

  logic [COLS*CW-1:0] acc_flat;

  for (genvar c = 0; c < COLS; c++) begin : col_g
    logic [CW-1:0] acc_q, acc_d;
    logic          hit;

    always_comb begin
      hit   = take_i && (grp_i == GW'(c / KW));
      acc_d = acc_q;
      if (start_i)  acc_d = '0;
      if (hit)      acc_d = (start_i ? '0 : acc_q) + CW'(bits_i[c % KW]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                acc_q <= '0;
      else if (take_i)           acc_q <= acc_d;
    end

    assign acc_flat[c*CW +: CW] = acc_q;
  end

  always_comb begin
    for (int i = 0; i < KW; i++) begin
      rd_vals_o[i*CW +: CW] = acc_flat[(int'(rd_grp_i) * KW + i) * CW +: CW];
    end
  end

endmodule

// File: rtl/pcl_col_search.sv
module pcl_col_search #(
  parameter int COLS = 560,
  parameter int ROWS = 480,
  parameter int KW   = 8,
  parameter int GW   = pcl_pkg::idx_w(COLS / KW),
  parameter int CW   = $clog2(ROWS + 1),
  parameter int XW   = pcl_pkg::idx_w(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_search_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic [GW-1:0]    sgrp_i,
  input  logic [KW*CW-1:0] vals_i,
  output logic [XW-1:0]    idx_o
);

  logic [CW-1:0] best_val_q, best_val_d;
  logic [XW-1:0] best_idx_q, best_idx_d;

  // strict compare from the lowest column upward keeps the lowest index on ties
  always_comb begin
    best_val_d = first_i ? '0 : best_val_q;
    best_idx_d = first_i ? '0 : best_idx_q;
    for (int i = 0; i < KW; i++) begin
      if (vals_i[i*CW +: CW] > best_val_d) begin
        best_val_d = vals_i[i*CW +: CW];
        best_idx_d = XW'(int'(sgrp_i) * KW + i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_val_q <= '0;
      best_idx_q <= '0;
    end else if (in_search_i) begin
      best_val_q <= best_val_d;
      best_idx_q <= best_idx_d;
    end
  end

  assign idx_o = best_idx_d;

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_i |-> (int'(idx_o) < COLS));

endmodule

// File: rtl/pcl_row_peak.sv
module pcl_row_peak #(
  parameter int COLS = 560,
  parameter int ROWS = 480,
  parameter int KW   = 8,
  parameter int LW   = pcl_pkg::idx_w(ROWS),
  parameter int YW   = pcl_pkg::idx_w(ROWS),
  parameter int SW   = $clog2(COLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic          start_i,
  input  logic          eol_i,
  input  logic [KW-1:0] bits_i,
  input  logic [LW-1:0] line_i,
  output logic [SW-1:0] max_o,
  output logic [YW-1:0] y_o
);

  logic [SW-1:0] sum_q, sum_d, sum_new, max_q, max_d, max_cur;
  logic [YW-1:0] y_q, y_d;
  logic [SW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < KW; i++) ones = ones + SW'(bits_i[i]);
    sum_new = (start_i ? '0 : sum_q) + ones;
    max_cur = start_i ? '0 : max_q;
    sum_d   = sum_new;
    max_d   = max_cur;
    y_d     = start_i ? '0 : y_q;
    if (eol_i) begin
      sum_d = '0;
      if (sum_new > max_cur) begin
        max_d = sum_new;
        y_d   = YW'(ROWS - 1 - int'(line_i));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      max_q <= '0;
      y_q   <= '0;
    end else if (take_i) begin
      sum_q <= sum_d;
      max_q <= max_d;
      y_q   <= y_d;
    end
  end

  assign max_o = max_q;
  assign y_o   = y_q;

  // R4
  max_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start_i) |-> (max_q >= $past(max_q)));

  // R4
  row_sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sum_q) <= COLS);

endmodule

// File: rtl/peak_centroid_locator.sv
module peak_centroid_locator
  import pcl_pkg::*;
#(
  parameter int COLS = 560,
  parameter int ROWS = 480,
  parameter int KW   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   kin_valid,
  input  logic [KW-1:0]          kin_bits,
  input  logic                   kin_sof,
  input  logic                   kin_eol,
  output logic [idx_w(COLS)-1:0] cx,
  output logic [idx_w(ROWS)-1:0] cy,
  output logic                   fix_done,
  output logic                   no_target
);

  localparam int NG = COLS / KW;
  localparam int GW = idx_w(NG);
  localparam int LW = idx_w(ROWS);
  localparam int XW = idx_w(COLS);
  localparam int YW = idx_w(ROWS);
  localparam int CW = $clog2(ROWS + 1);
  localparam int SW = $clog2(COLS + 1);

  logic             take, start, in_search, s_first, s_last;
  logic [GW-1:0]    grp, sgrp;
  logic [LW-1:0]    line;
  logic [KW*CW-1:0] rd_vals;
  logic [XW-1:0]    peak_x;
  logic [SW-1:0]    row_max;
  logic [YW-1:0]    row_y;

  pcl_frame_seq #(.COLS(COLS), .ROWS(ROWS), .KW(KW), .GW(GW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .valid_i(kin_valid), .sof_i(kin_sof), .eol_i(kin_eol),
    .take_o(take), .start_o(start), .grp_o(grp), .line_o(line),
    .in_search_o(in_search), .search_first_o(s_first),
    .search_last_o(s_last), .sgrp_o(sgrp)
  );

  pcl_col_bank #(.COLS(COLS), .ROWS(ROWS), .KW(KW), .GW(GW), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .take_i(take), .start_i(start), .grp_i(grp), .bits_i(kin_bits),
    .rd_grp_i(sgrp), .rd_vals_o(rd_vals)
  );

  pcl_col_search #(.COLS(COLS), .ROWS(ROWS), .KW(KW), .GW(GW), .CW(CW), .XW(XW)) u_srch (
    .clk(clk), .rst_n(rst_n),
    .in_search_i(in_search), .first_i(s_first), .last_i(s_last),
    .sgrp_i(sgrp), .vals_i(rd_vals), .idx_o(peak_x)
  );

  pcl_row_peak #(.COLS(COLS), .ROWS(ROWS), .KW(KW), .LW(LW), .YW(YW), .SW(SW)) u_row (
    .clk(clk), .rst_n(rst_n),
    .take_i(take), .start_i(start), .eol_i(kin_eol), .bits_i(kin_bits),
    .line_i(line), .max_o(row_max), .y_o(row_y)
  );

  logic [XW-1:0] cx_d;
  logic [YW-1:0] cy_d;
  logic          nt_d;

  always_comb begin
    cx_d = cx;
    cy_d = cy;
    nt_d = no_target;
    if (s_last) begin
      cx_d = peak_x;
      cy_d = row_y;
      nt_d = (row_max == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cx        <= '0;
      cy        <= '0;
      no_target <= 1'b0;
      fix_done  <= 1'b0;
    end else begin
      fix_done <= s_last;
      if (s_last) begin
        cx        <= cx_d;
        cy        <= cy_d;
        no_target <= nt_d;
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_done |=> !fix_done);

  // R8
  no_target_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_done && no_target) |-> (cx == '0 && cy == '0));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fix_done |-> ($stable(cx) && $stable(cy) && $stable(no_target)));

endmodule

// File: tb/test_peak_centroid_locator.sv
module test_peak_centroid_locator;

  localparam int CLK_PERIOD = 10;
  localparam int COLS = 32;
  localparam int ROWS = 10;
  localparam int KW   = 8;
  localparam int NG   = COLS / KW;
  localparam int XW   = $clog2(COLS);
  localparam int YW   = $clog2(ROWS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          kin_valid = 1'b0;
  logic [KW-1:0] kin_bits = '0;
  logic          kin_sof = 1'b0;
  logic          kin_eol = 1'b0;
  logic [XW-1:0] cx;
  logic [YW-1:0] cy;
  logic          fix_done;
  logic          no_target;

  always #(CLK_PERIOD / 2) clk = ~clk;

  peak_centroid_locator #(.COLS(COLS), .ROWS(ROWS), .KW(KW)) i_peak_centroid_locator (
    .clk(clk), .rst_n(rst_n), .kin_valid(kin_valid), .kin_bits(kin_bits),
    .kin_sof(kin_sof), .kin_eol(kin_eol), .cx(cx), .cy(cy),
    .fix_done(fix_done), .no_target(no_target)
  );

  bit    img [ROWS][COLS];   // indexed by arrival line, then column
  int    cyc = 0;
  int    done_at = -1;
  int    vectors = 0;
  int    errors = 0;
  int    pend_x = 0, pend_y = 0;
  bit    pend_nt = 0;
  int    exp_x = 0, exp_y = 0;
  bit    exp_nt = 0;
  bit    exp_done;
  string scen = "R1";

  // reference comparison on every falling edge
  always @(negedge clk) begin
    cyc++;
    exp_done = (cyc == done_at);
    if (exp_done) begin
      exp_x  = pend_x;
      exp_y  = pend_y;
      exp_nt = pend_nt;
    end
    vectors++;
    if (fix_done !== exp_done) begin
      errors++;
      $display("FAIL R6 [%s] cycle %0d fix_done=%0b expected %0b", scen, cyc, fix_done, exp_done);
    end
    if (int'(cx) != exp_x || $isunknown(cx)) begin
      errors++;
      $display("FAIL R3 [%s] cycle %0d cx=%0d expected %0d", scen, cyc, cx, exp_x);
    end
    if (int'(cy) != exp_y || $isunknown(cy)) begin
      errors++;
      $display("FAIL R5 [%s] cycle %0d cy=%0d expected %0d", scen, cyc, cy, exp_y);
    end
    if (no_target !== exp_nt) begin
      errors++;
      $display("FAIL R8 [%s] cycle %0d no_target=%0b expected %0b", scen, cyc, no_target, exp_nt);
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog [%s] cycle %0d reached, expected completion", scen, cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  function automatic void clear_img();
    for (int l = 0; l < ROWS; l++)
      for (int c = 0; c < COLS; c++) img[l][c] = 1'b0;
  endfunction

  function automatic void draw_disc(input int xc, input int lc, input int r);
    for (int l = 0; l < ROWS; l++)
      for (int c = 0; c < COLS; c++)
        if ((c - xc) * (c - xc) + (l - lc) * (l - lc) <= r * r) img[l][c] = 1'b1;
  endfunction

  // R3 / R4 / R5 / R8 expectation from the image alone
  task automatic predict(output int ex, output int ey, output bit ent);
    int best_c, best_cnt, best_l, best_sum, total;
    best_c = 0; best_cnt = 0; best_l = -1; best_sum = 0; total = 0;
    for (int c = 0; c < COLS; c++) begin
      int n = 0;
      for (int l = 0; l < ROWS; l++) n += int'(img[l][c]);
      if (n > best_cnt) begin best_cnt = n; best_c = c; end
    end
    for (int l = 0; l < ROWS; l++) begin
      int s = 0;
      for (int c = 0; c < COLS; c++) s += int'(img[l][c]);
      total += s;
      if (s > best_sum) begin best_sum = s; best_l = l; end
    end
    ent = (total == 0);
    ex  = best_c;
    ey  = (best_l < 0) ? 0 : ROWS - 1 - best_l;
  endtask

  // R2 / R11: bit i of kernel k is column KW*k+i; idle gaps carry junk
  task automatic send_frame(input int gap_pct);
    int ex, ey; bit ent;
    predict(ex, ey, ent);
    for (int l = 0; l < ROWS; l++) begin
      for (int k = 0; k < NG; k++) begin
        while (int'($urandom_range(99)) < gap_pct) begin
          @(negedge clk);
          kin_valid = 1'b0;
          kin_bits  = KW'($urandom);
          kin_sof   = 1'($urandom);
          kin_eol   = 1'($urandom);
        end
        @(negedge clk);
        kin_valid = 1'b1;
        for (int i = 0; i < KW; i++) kin_bits[i] = img[l][k*KW + i];
        kin_sof = (l == 0 && k == 0);
        kin_eol = (k == NG - 1);
        @(posedge clk);
        if (l == ROWS - 1 && k == NG - 1) begin
          done_at = cyc + NG + 1;
          pend_x  = ex;
          pend_y  = ey;
          pend_nt = ent;
        end
      end
    end
    // R9: stray kernels during the search must be dropped
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      kin_valid = 1'b1;
      kin_bits  = '1;
      kin_sof   = (j != 1);
      kin_eol   = 1'b1;
    end
    @(negedge clk);
    kin_valid = 1'b0;
    kin_sof   = 1'b0;
    kin_eol   = 1'b0;
    while (cyc <= done_at + 1) @(negedge clk);
  endtask

  initial begin
    scen = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    scen = "R2 R3 R5 disc";
    clear_img(); draw_disc(13, 4, 3);
    send_frame(0);

    scen = "R8 R10 empty";
    clear_img();
    send_frame(0);

    scen = "R3 R4 ties";
    clear_img();
    for (int l = 2; l <= 4; l++) img[l][5] = 1'b1;
    for (int l = 6; l <= 8; l++) img[l][20] = 1'b1;
    send_frame(0);

    scen = "R2 R5 corner";
    clear_img(); img[ROWS-1][COLS-1] = 1'b1;
    send_frame(10);

    scen = "R4 full line and column";
    clear_img();
    for (int c = 0; c < COLS; c++) img[0][c] = 1'b1;
    for (int l = 0; l < ROWS; l++) img[l][17] = 1'b1;
    send_frame(0);

    scen = "R2 left edge";
    clear_img(); img[3][0] = 1'b1; img[4][0] = 1'b1; img[4][8] = 1'b1;
    send_frame(0);

    for (int f = 0; f < 10; f++) begin
      scen = "R11 random";
      clear_img();
      draw_disc(int'($urandom_range(COLS - 1)), int'($urandom_range(ROWS - 1)),
                int'($urandom_range(3, 1)));
      for (int n = 0; n < 4; n++)
        img[$urandom_range(ROWS - 1)][$urandom_range(COLS - 1)] = 1'b1;
      send_frame(30);
    end

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule